// File: doc/BRIEF.md
# Windowed Offset and AC Load Qualifier

This block turns raw per-channel comparator activity from an amplifier's output stages into two confirmed diagnostic results. The first is a DC-offset verdict: a channel is flagged only if its offset comparator stayed asserted through a whole measurement window chosen by the host. The second is an AC-coupled load verdict: a channel counts as open unless at least a minimum number of distinct current peaks (three by default) crossed the selected threshold during its window. Each result also carries a void bit. The void bit is set when the window produced no usable measurement, either because the check was not enabled or because the short-circuit protection fired during the window.

A window opens in the clock cycle where its enable rises, or in the cycle right after a read strobe while the enable stays high. The window closes at the read strobe, and that read cycle is part of the window. The results are registered on the read and hold until the next read. A read therefore always returns the verdict of the window it closes and restarts the measurement. The offset check and the load check keep separate windows because each has its own enable. The channels are fully independent of each other. The analog comparators sit outside this block.

Top module: `win_qualifier`

## Requirements
- R1: After reset every ofs_fault and ac_open bit is 0 and every ofs_void and ac_void bit is 1.
- R2: If ofs_flag of a channel is 1 in every cycle from the enable-rise cycle through the read cycle, with no overload, then ofs_fault of that channel is 1 and ofs_void is 0 in the cycle after the read.
- R3: A single cycle with ofs_flag at 0 inside the window makes ofs_fault 0 for that window, with ofs_void 0.
- R4: A read with ofs_en high starts a new window in the next cycle. The next result depends only on that new window.
- R5: If ofs_en is 0 in the read cycle, the read yields ofs_void 1 and ofs_fault 0 for all channels.
- R6: With ac_en high, at least three rising edges of the selected peak comparator within the window give ac_open 0. Fewer give ac_open 1. In both cases ac_void is 0.
- R7: A peak comparator held high for several cycles counts as one peak.
- R8: thr_lo = 0 selects pk_hi as the peak source and thr_lo = 1 selects pk_lo. The unselected input has no effect.
- R9: An ovl pulse on a channel in any cycle of a window, including the read cycle, makes that channel's void bits 1 and its ofs_fault and ac_open bits 0.
- R10: If ac_en is 0 in the read cycle, the read yields ac_void 1 and ac_open 0 for all channels.
- R11: Each channel's result depends only on that channel's inputs.
- R12: The outputs change only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ofs_en | input | 1 | Offset check enable |
| ac_en | input | 1 | AC load check enable |
| thr_lo | input | 1 | Threshold pair select: 0 uses pk_hi, 1 uses pk_lo |
| rd | input | 1 | Read strobe: closes and restarts the windows |
| ofs_flag | input | NUM_CH | Offset comparator output per channel |
| pk_hi | input | NUM_CH | Peak-over-high-threshold comparator per channel |
| pk_lo | input | NUM_CH | Peak-over-low-threshold comparator per channel |
| ovl | input | NUM_CH | Short-circuit protection active per channel |
| ofs_fault | output | NUM_CH | Confirmed excess offset |
| ofs_void | output | NUM_CH | Offset result not valid |
| ac_open | output | NUM_CH | Too few peaks: load considered open |
| ac_void | output | NUM_CH | AC result not valid |

## Verification
A wrong internal state stays hidden until the next read. Only in the cycle after that read does it show at the ports, as a wrong fault, open or void bit on one channel. For this reason every scenario ends in a read, and the bench compares all four output vectors in the cycle that follows. A persistence bit that is not restarted shows up as a stale fault in the second of two back-to-back windows. A peak counter that counts levels instead of edges turns a long pulse plus a short one into a pass. An overload latch that misses the read cycle leaves the void bit at 0 on that read.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int unsigned WQ_CH_DEF    = 4;
  localparam int unsigned WQ_PEAKS_DEF = 3;
endpackage

// File: rtl/wq_offset_win.sv
module wq_offset_win (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rd,
  input  logic flag,
  input  logic ovl,
  output logic fault,
  output logic void_o
);
  logic en_q, active, ok, ov;
  logic rise;
  assign rise = en & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      active <= 1'b0;
      ok     <= 1'b0;
      ov     <= 1'b0;
      fault  <= 1'b0;
      void_o <= 1'b1;
    end else begin
      en_q <= en;
      if (rd) begin
        fault  <= active & en & ok & flag & ~(ov | ovl);
        void_o <= ~active | ~en | ov | ovl;
      end
      if (!en) begin
        active <= 1'b0;
      end else if (rd) begin
        active <= 1'b1;
        ok     <= 1'b1;
        ov     <= 1'b0;
      end else if (rise) begin
        active <= 1'b1;
        ok     <= flag;
        ov     <= ovl;
      end else if (active) begin
        ok <= ok & flag;
        ov <= ov | ovl;
      end
    end
  end

  // R12
  ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> ($stable(fault) && $stable(void_o)));
  // R9
  ofs_ovl_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && ovl) |=> (void_o && !fault));
  // R3
  ofs_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !flag) |=> !fault);
  // R5
  ofs_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !en) |=> (void_o && !fault));
endmodule

// File: rtl/wq_load_win.sv
module wq_load_win #(
  parameter int unsigned PEAK_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rd,
  input  logic thr_lo,
  input  logic pk_hi,
  input  logic pk_lo,
  input  logic ovl,
  output logic open_o,
  output logic void_o
);
  localparam int unsigned CW = $clog2(PEAK_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(PEAK_MIN);

  logic en_q, active, ov, pk_q;
  logic [CW-1:0] cnt, cnt_nx;
  logic pk, edge_w, rise;

  assign pk     = thr_lo ? pk_lo : pk_hi;
  assign edge_w = pk & ~pk_q;
  assign rise   = en & ~en_q;
  assign cnt_nx = (cnt == CMAX) ? cnt : cnt + CW'(edge_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      active <= 1'b0;
      ov     <= 1'b0;
      pk_q   <= 1'b0;
      cnt    <= '0;
      open_o <= 1'b0;
      void_o <= 1'b1;
    end else begin
      en_q <= en;
      pk_q <= pk;
      if (rd) begin
        open_o <= active & en & ~(ov | ovl) & (cnt_nx < CMAX);
        void_o <= ~active | ~en | ov | ovl;
      end
      if (!en) begin
        active <= 1'b0;
      end else if (rd) begin
        active <= 1'b1;
        cnt    <= '0;
        ov     <= 1'b0;
      end else if (rise) begin
        active <= 1'b1;
        cnt    <= CW'(edge_w);
        ov     <= ovl;
      end else if (active) begin
        cnt <= cnt_nx;
        ov  <= ov | ovl;
      end
    end
  end

  // R12
  ac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> ($stable(open_o) && $stable(void_o)));
  // R9
  ac_ovl_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && ovl) |=> (void_o && !open_o));
  // R10
  ac_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !en) |=> (void_o && !open_o));
  // R6
  ac_excl_chk: assert property (@(posedge clk) disable iff (rst)
    open_o |-> !void_o);
endmodule

// File: rtl/win_qualifier.sv
module win_qualifier #(
  parameter int unsigned NUM_CH   = wq_pkg::WQ_CH_DEF,
  parameter int unsigned PEAK_MIN = wq_pkg::WQ_PEAKS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ofs_en,
  input  logic              ac_en,
  input  logic              thr_lo,
  input  logic              rd,
  input  logic [NUM_CH-1:0] ofs_flag,
  input  logic [NUM_CH-1:0] pk_hi,
  input  logic [NUM_CH-1:0] pk_lo,
  input  logic [NUM_CH-1:0] ovl,
  output logic [NUM_CH-1:0] ofs_fault,
  output logic [NUM_CH-1:0] ofs_void,
  output logic [NUM_CH-1:0] ac_open,
  output logic [NUM_CH-1:0] ac_void
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wq_offset_win u_ofs (
      .clk(clk), .rst(rst), .en(ofs_en), .rd(rd),
      .flag(ofs_flag[c]), .ovl(ovl[c]),
      .fault(ofs_fault[c]), .void_o(ofs_void[c])
    );
    wq_load_win #(.PEAK_MIN(PEAK_MIN)) u_ac (
      .clk(clk), .rst(rst), .en(ac_en), .rd(rd), .thr_lo(thr_lo),
      .pk_hi(pk_hi[c]), .pk_lo(pk_lo[c]), .ovl(ovl[c]),
      .open_o(ac_open[c]), .void_o(ac_void[c])
    );
  end
endmodule

// File: tb/win_qualifier_tb.sv
module win_qualifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, ofs_en, ac_en, thr_lo, rd;
  logic [N-1:0] ofs_flag, pk_hi, pk_lo, ovl;
  logic [N-1:0] ofs_fault, ofs_void, ac_open, ac_void;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_qualifier #(.NUM_CH(N), .PEAK_MIN(3)) u_dut (
    .clk(clk), .rst(rst), .ofs_en(ofs_en), .ac_en(ac_en), .thr_lo(thr_lo),
    .rd(rd), .ofs_flag(ofs_flag), .pk_hi(pk_hi), .pk_lo(pk_lo), .ovl(ovl),
    .ofs_fault(ofs_fault), .ofs_void(ofs_void), .ac_open(ac_open), .ac_void(ac_void)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [N-1:0] ovl_mask = '0);
    rd = 1'b1; ovl = ovl_mask;
    step();
    rd = 1'b0; ovl = '0;
  endtask

  task automatic peaks_hi(input logic [N-1:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      pk_hi = pk_hi | m; step();
      pk_hi = pk_hi & ~m; step();
    end
  endtask

  task automatic peaks_lo(input logic [N-1:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      pk_lo = pk_lo | m; step();
      pk_lo = pk_lo & ~m; step();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; ofs_en = 0; ac_en = 0; thr_lo = 0; rd = 0;
    ofs_flag = '0; pk_hi = '0; pk_lo = '0; ovl = '0;
    step(3);
    rst = 1'b0;
    step();
    chk("R1 ofs_fault", ofs_fault, 4'b0000);
    chk("R1 ofs_void", ofs_void, 4'b1111);
    chk("R1 ac_open", ac_open, 4'b0000);
    chk("R1 ac_void", ac_void, 4'b1111);
  endtask

  task automatic t_persist();
    ofs_flag = 4'b0111; ofs_en = 1'b1;
    step(2);
    ofs_flag[1] = 1'b0; step();
    ofs_flag[1] = 1'b1; step(2);
    do_read();
    chk("R2/R3/R11 ofs_fault", ofs_fault, 4'b0101);
    chk("R2/R3 ofs_void", ofs_void, 4'b0000);
  endtask

  task automatic t_rewindow();
    ofs_flag = 4'b1010;
    step(4);
    do_read();
    chk("R4 fresh window fault", ofs_fault, 4'b1010);
    ofs_flag = 4'b1111;
    step(3);
    chk("R12 outputs hold between reads", ofs_fault, 4'b1010);
    do_read();
    chk("R4 window after read", ofs_fault, 4'b1111);
  endtask

  task automatic t_ofs_off();
    ofs_en = 1'b0;
    step(2);
    do_read();
    chk("R5 ofs_void", ofs_void, 4'b1111);
    chk("R5 ofs_fault", ofs_fault, 4'b0000);
  endtask

  task automatic t_overload();
    ofs_flag = 4'b1111; ofs_en = 1'b1; ac_en = 1'b1; thr_lo = 1'b0;
    step();
    peaks_hi(4'b1111, 1);
    ovl = 4'b0100; step(); ovl = '0;
    peaks_hi(4'b1111, 2);
    do_read();
    chk("R9 ofs_fault", ofs_fault, 4'b1011);
    chk("R9 ofs_void", ofs_void, 4'b0100);
    chk("R9 ac_open", ac_open, 4'b0000);
    chk("R9 ac_void", ac_void, 4'b0100);
  endtask

  task automatic t_count();
    pk_hi[0] = 1'b1; step(); pk_hi[0] = 1'b0; step();
    pk_hi[0] = 1'b1; step(); pk_hi[0] = 1'b0; step();
    pk_hi[0] = 1'b1; step(); pk_hi[0] = 1'b0; step();
    peaks_hi(4'b0010, 2);
    pk_hi[2] = 1'b1; step(4); pk_hi[2] = 1'b0; step();
    peaks_hi(4'b0100, 1);
    do_read();
    chk("R6/R7/R11 ac_open", ac_open, 4'b1110);
    chk("R6 ac_void", ac_void, 4'b0000);
  endtask

  task automatic t_thr();
    thr_lo = 1'b1;
    step();
    do_read();
    peaks_hi(4'b1111, 3);
    peaks_lo(4'b1010, 3);
    do_read();
    chk("R8 lo source, hi ignored", ac_open, 4'b0101);
    thr_lo = 1'b0;
    step();
    do_read();
    peaks_lo(4'b1111, 3);
    peaks_hi(4'b0001, 3);
    do_read();
    chk("R8 hi source, lo ignored", ac_open, 4'b1110);
  endtask

  task automatic t_ovl_read();
    ofs_flag = 4'b1111;
    step();
    peaks_hi(4'b1111, 3);
    do_read(4'b0001);
    chk("R9 read-cycle ovl ofs_void", ofs_void, 4'b0001);
    chk("R9 read-cycle ovl ofs_fault", ofs_fault, 4'b1110);
    chk("R9 read-cycle ovl ac_void", ac_void, 4'b0001);
    chk("R9 read-cycle ovl ac_open", ac_open, 4'b0000);
  endtask

  task automatic t_ac_off();
    ac_en = 1'b0;
    peaks_hi(4'b1111, 1);
    do_read();
    chk("R10 ac_void", ac_void, 4'b1111);
    chk("R10 ac_open", ac_open, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_persist();
    t_rewindow();
    t_ofs_off();
    t_overload();
    t_count();
    t_thr();
    t_ovl_read();
    t_ac_off();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule